// File: doc/BRIEF.md
# Instruction-Injecting Interrupt Controller

This controller sits next to an 8-bit processor that does no interrupt vectoring of its own. It collects up to eight active-high request lines, keeps a pending bit for each, and raises one interrupt request to the processor. When the processor acknowledges, the controller does not return an address. It places a complete instruction on the shared data bus, one byte for each interrupt-read strobe. The processor executes that instruction as if it had been fetched from memory.

Two injection modes exist. In restart mode the controller supplies the single byte `11nnn111`, where `nnn` is the number of the winning line, so the processor continues at address 8×n. In call mode it supplies a three-byte subroutine call to `base + 4×n`, where `base` is a 16-bit register. Lines can be masked one at a time. A four-register write port sets the mask, the mode and the base.

The control is a four-state machine. `ST_IDLE` moves to `ST_REQ` when an unmasked line is pending. `ST_REQ` drives the request, moves to `ST_SERVE` on acknowledge and latches the winner and the mode, and returns to `ST_IDLE` if every pending line becomes masked. `ST_SERVE` delivers the bytes. It moves to `ST_DRAIN` after the final byte and clears that line's pending bit, and it returns to `ST_IDLE` if acknowledge drops early. `ST_DRAIN` waits for acknowledge to fall, then returns to `ST_IDLE`.

Top module: `irq_inject_ctrl`

## Requirements
- R1: After reset `cpu_intr` is low, the data bus is not driven, every line is unmasked, restart mode is selected, the call base is 0 and nothing is pending.
- R2: A request line that is high at a single clock edge is remembered as pending. `cpu_intr` rises after the second clock edge that follows that sample.
- R3: A pending line whose mask bit is set does not raise `cpu_intr`. It stays pending, and it raises `cpu_intr` once its mask bit is cleared.
- R4: When several unmasked lines are pending, the lowest-numbered line is served first.
- R5: In restart mode one byte is injected, equal to `{2'b11, n[2:0], 3'b111}` for line n.
- R6: In call mode three bytes are injected in this order: 0xCD, the low byte of `base + 4×n`, then the high byte. The sum wraps modulo 2^16.
- R7: The byte index advances once for each strobe, when the strobe falls. The data bus is driven only while `int_rd` is high in the serving state, and it floats at all other times.
- R8: `cpu_intr` is low in every cycle after the first acknowledged cycle, until `cpu_inta` has dropped.
- R9: The winning line and the mode are latched when acknowledge is seen. Requests that arrive later, including requests of higher priority, do not change the bytes of the instruction in progress.
- R10: The served line's pending bit is cleared when the strobe of its final byte falls. Unless that line is requested again, no new request follows.
- R11: Register writes with `cfg_we` high take effect at the clock edge. Address 0 holds the mask, where bit n masks line n. Address 1 holds the mode in bit 0, where 1 selects call. Address 2 holds the low byte of the call base and address 3 holds the high byte.
- R12: If `cpu_inta` drops before the final byte has been taken, the injection is abandoned and the line stays pending, so `cpu_intr` is raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | NUM_LINES | Request lines, active high, line 0 highest priority |
| cpu_intr | output | 1 | Interrupt request to the processor |
| cpu_inta | input | 1 | Acknowledge from the processor, held for the whole injected fetch |
| int_rd | input | 1 | Interrupt-read strobe, high for one read of one byte |
| data_bus | inout | 8 | Shared data bus, driven only during an injection read |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |

## Verification
The embedded assertions watch on every cycle that the request stays low once acknowledge has been held, that the latched winner does not move during an injection, that the byte index only steps by one, that the served line's pending bit is gone on entry to the drain state, and that every request rise was caused by an eligible pending line. Only the bench scenarios can show the byte values: restart encodings, the call target with carry into the high byte, the order of service when two lines collide, masking followed by unmasking, and the recovery after an abandoned acknowledge. A behavioural model in the bench also compares the request line and the bus contents, including the floating bus, on every clock.

// File: rtl/irq_inj_pkg.sv
package irq_inj_pkg;

    localparam int BUS_W  = 8;
    localparam int BASE_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_SERVE,
        ST_DRAIN
    } inj_state_e;

    localparam logic [BUS_W-1:0] OPC_CALL    = 8'hCD;
    localparam logic [1:0]       SEL_MASK    = 2'd0;
    localparam logic [1:0]       SEL_MODE    = 2'd1;
    localparam logic [1:0]       SEL_BASE_LO = 2'd2;
    localparam logic [1:0]       SEL_BASE_HI = 2'd3;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_inj_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [1:0]           sel,
    input  logic [BUS_W-1:0]     wdata,
    output logic [NUM_LINES-1:0] mask,
    output logic                 call_mode,
    output logic [BASE_W-1:0]    base
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask      <= '0;
            call_mode <= 1'b0;
            base      <= '0;
        end else if (we) begin
            unique case (sel)
                SEL_MASK:    mask        <= wdata[NUM_LINES-1:0];
                SEL_MODE:    call_mode   <= wdata[0];
                SEL_BASE_LO: base[7:0]   <= wdata;
                SEL_BASE_HI: base[15:8]  <= wdata;
            endcase
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0] req,
    output logic                 any,
    output logic [IDX_W-1:0]     idx
);

    always_comb begin
        idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    assign any = |req;

endmodule

// File: rtl/irq_byte_gen.sv
module irq_byte_gen
    import irq_inj_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                call_mode,
    input  logic [IDX_W-1:0]    line,
    input  logic [1:0]          index,
    input  logic [BASE_W-1:0]   base,
    output logic [BUS_W-1:0]    byte_out
);

    logic [2:0]        line3;
    logic [BASE_W-1:0] target;

    generate
        if (IDX_W >= 3) begin : g_wide
            assign line3 = line[2:0];
        end else begin : g_narrow
            assign line3 = {{(3-IDX_W){1'b0}}, line};
        end
    endgenerate

    assign target = base + (BASE_W'(line) << 2);

    always_comb begin
        if (!call_mode) begin
            byte_out = {2'b11, line3, 3'b111};
        end else begin
            unique case (index)
                2'd0:    byte_out = OPC_CALL;
                2'd1:    byte_out = target[7:0];
                default: byte_out = target[15:8];
            endcase
        end
    end

endmodule

// File: rtl/irq_inject_ctrl.sv
module irq_inject_ctrl
    import irq_inj_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    output logic                 cpu_intr,
    input  logic                 cpu_inta,
    input  logic                 int_rd,
    inout  wire  [7:0]           data_bus,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_addr,
    input  logic [7:0]           cfg_wdata
);

    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    inj_state_e             state_q, state_d;
    logic [NUM_LINES-1:0]   pend_q, eligible, clr_vec, mask;
    logic [IDX_W-1:0]       win_q, pick_idx;
    logic [1:0]             cnt_q, last_cnt;
    logic                   mode_q, rd_q, rd_fall, any_elig, done;
    logic                   call_mode, bus_oe;
    logic [BASE_W-1:0]      base;
    logic [BUS_W-1:0]       inj_byte;

    irq_cfg_regs #(.NUM_LINES(NUM_LINES)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_addr),
        .wdata(cfg_wdata), .mask(mask), .call_mode(call_mode), .base(base)
    );

    assign eligible = pend_q & ~mask;

    irq_prio_pick #(.NUM_LINES(NUM_LINES)) u_pick (
        .req(eligible), .any(any_elig), .idx(pick_idx)
    );

    irq_byte_gen #(.NUM_LINES(NUM_LINES)) u_bytes (
        .call_mode(mode_q), .line(win_q), .index(cnt_q),
        .base(base), .byte_out(inj_byte)
    );

    assign rd_fall  = rd_q & ~int_rd;
    assign last_cnt = mode_q ? 2'd2 : 2'd0;
    assign done     = (state_q == ST_SERVE) && cpu_inta && rd_fall
                      && (cnt_q == last_cnt);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (any_elig) state_d = ST_REQ;
            ST_REQ: begin
                if (cpu_inta)       state_d = ST_SERVE;
                else if (!any_elig) state_d = ST_IDLE;
            end
            ST_SERVE: begin
                if (!cpu_inta)      state_d = ST_IDLE;
                else if (done)      state_d = ST_DRAIN;
            end
            ST_DRAIN: if (!cpu_inta) state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cpu_intr = (state_q == ST_REQ);
        bus_oe   = (state_q == ST_SERVE) && int_rd;
    end

    assign data_bus = bus_oe ? inj_byte : 8'hzz;

    // served-line clear vector
    always_comb begin
        clr_vec = '0;
        if (done) clr_vec[win_q] = 1'b1;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            win_q  <= '0;
            cnt_q  <= '0;
            mode_q <= 1'b0;
            rd_q   <= 1'b0;
        end else begin
            rd_q   <= int_rd;
            pend_q <= (pend_q & ~clr_vec) | irq_lines;
            if (state_q == ST_REQ && cpu_inta) begin
                win_q  <= pick_idx;
                cnt_q  <= '0;
                mode_q <= call_mode;
            end else if (state_q == ST_SERVE && cpu_inta && rd_fall && !done) begin
                cnt_q  <= cnt_q + 2'd1;
            end
        end
    end

    AST_NO_INTR_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_REQ && $past(cpu_inta)) |-> !cpu_intr); // R8

    AST_WIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_SERVE && state_q != ST_IDLE) |-> ($stable(win_q) && $stable(mode_q))); // R9

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_SERVE && state_q == ST_SERVE)
        |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 2'd1)); // R7

    AST_CLR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_SERVE && state_q == ST_DRAIN)
        |-> (!pend_q[win_q] || $past(irq_lines[win_q]))); // R10

    AST_INTR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_intr) |-> $past(any_elig)); // R3

endmodule

// File: tb/irq_inject_ctrl_tb.sv
`timescale 1ns/1ps
module irq_inject_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_lines = '0;
    logic       cpu_inta = 1'b0;
    logic       int_rd = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       cpu_intr;
    wire  [7:0] data_bus;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    for (genvar i = 0; i < 8; i++) begin : g_pull
        pullup (data_bus[i]);
    end

    irq_inject_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .cpu_intr(cpu_intr),
        .cpu_inta(cpu_inta), .int_rd(int_rd), .data_bus(data_bus),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0]  m_pend, m_mask, m_clr;
    logic [15:0] m_base;
    bit          m_mode, m_mode_l, m_rdq;
    int          m_phase, m_cnt, m_win;

    function automatic logic [7:0] model_byte(int win, int cnt, bit call, logic [15:0] base);
        logic [15:0] tgt;
        tgt = base + 16'(win * 4);
        if (!call)         return 8'hC7 | 8'(win << 3);
        else if (cnt == 0) return 8'hCD;
        else if (cnt == 1) return tgt[7:0];
        else               return tgt[15:8];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend = '0; m_mask = '0; m_base = '0; m_mode = 0; m_mode_l = 0;
            m_rdq = 0; m_phase = 0; m_cnt = 0; m_win = 0;
        end else begin
            logic [7:0] elig;
            int pick;
            elig = m_pend & ~m_mask;
            pick = 0;
            for (int i = 7; i >= 0; i--) if (elig[i]) pick = i;
            m_clr = '0;
            case (m_phase)
                0: if (elig != 0) m_phase = 1;
                1: if (cpu_inta) begin
                       m_phase = 2; m_win = pick; m_cnt = 0; m_mode_l = m_mode;
                   end else if (elig == 0) m_phase = 0;
                2: if (!cpu_inta) m_phase = 0;
                   else if (m_rdq && !int_rd) begin
                       if (m_cnt == (m_mode_l ? 2 : 0)) begin
                           m_phase = 3; m_clr[m_win] = 1'b1;
                       end else m_cnt++;
                   end
                default: if (!cpu_inta) m_phase = 0;
            endcase
            m_pend = (m_pend & ~m_clr) | irq_lines;
            m_rdq  = int_rd;
            if (cfg_we) begin
                case (cfg_addr)
                    2'd0: m_mask = cfg_wdata;
                    2'd1: m_mode = cfg_wdata[0];
                    2'd2: m_base[7:0] = cfg_wdata;
                    default: m_base[15:8] = cfg_wdata;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [7:0] eb;
            eb = (m_phase == 2 && int_rd) ? model_byte(m_win, m_cnt, m_mode_l, m_base) : 8'hFF;
            check(cpu_intr == (m_phase == 1), "R8 model cpu_intr", int'(cpu_intr), int'(m_phase == 1));
            check(data_bus === eb, "R7 model bus", int'(data_bus), int'(eb));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1 cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1 cfg_we = 0;
    endtask

    task automatic pulse_line(input int n);
        @(posedge clk); #1 irq_lines[n] = 1'b1;
        @(posedge clk); #1 irq_lines[n] = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic wait_intr(input string tag);
        int t;
        t = 0;
        @(negedge clk);
        while (!cpu_intr && t < 40) begin @(negedge clk); t++; end
        check(cpu_intr == 1'b1, tag, int'(cpu_intr), 1);
    endtask

    task automatic serve(input int nb, input logic [7:0] e0, input logic [7:0] e1,
                         input logic [7:0] e2, input string tag, input int late_line);
        logic [7:0] exp_b [3];
        exp_b[0] = e0; exp_b[1] = e1; exp_b[2] = e2;
        wait_intr({tag, " request"});
        @(posedge clk); #1 cpu_inta = 1;
        @(posedge clk); #1;
        for (int b = 0; b < nb; b++) begin
            @(posedge clk); #1 int_rd = 1;
            @(negedge clk);
            check(data_bus === exp_b[b], tag, int'(data_bus), int'(exp_b[b]));
            check(cpu_intr == 1'b0, "R8 request low during ack", int'(cpu_intr), 0);
            @(posedge clk); #1 int_rd = 0;
            if (b == 0 && late_line >= 0) irq_lines[late_line] = 1'b1;
            @(negedge clk);
            check(data_bus === 8'hFF, "R7 bus floats between reads", int'(data_bus), 8'hFF);
            @(posedge clk); #1;
            if (late_line >= 0) irq_lines[late_line] = 1'b0;
        end
        @(posedge clk); #1 cpu_inta = 0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired: actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        idle(3);
        #1 rst_n = 1;
        @(negedge clk);
        check(cpu_intr == 1'b0, "R1 reset cpu_intr", int'(cpu_intr), 0);
        check(data_bus === 8'hFF, "R1 reset bus floats", int'(data_bus), 8'hFF);
        idle(3);
        @(negedge clk);
        check(cpu_intr == 1'b0, "R1 nothing pending after reset", int'(cpu_intr), 0);

        // R2 timing and R5 restart byte for line 3
        pulse_line(3);
        @(negedge clk);
        check(cpu_intr == 1'b0, "R2 request not yet raised", int'(cpu_intr), 0);
        @(negedge clk);
        check(cpu_intr == 1'b1, "R2 request after second edge", int'(cpu_intr), 1);
        serve(1, 8'hDF, 8'h00, 8'h00, "R5 restart line 3", -1);
        idle(6);
        @(negedge clk);
        check(cpu_intr == 1'b0, "R10 no repeat after service", int'(cpu_intr), 0);

        // R4 priority between lines 2 and 5
        @(posedge clk); #1 irq_lines = 8'h24;
        @(posedge clk); #1 irq_lines = 8'h00;
        serve(1, 8'hD7, 8'h00, 8'h00, "R4 first served line 2", -1);
        serve(1, 8'hEF, 8'h00, 8'h00, "R4 then line 5", -1);

        // R3 / R11 masking
        cfg_write(2'd0, 8'h10);
        pulse_line(4);
        idle(5);
        @(negedge clk);
        check(cpu_intr == 1'b0, "R3 masked line held off", int'(cpu_intr), 0);
        cfg_write(2'd0, 8'h00);
        idle(2);
        serve(1, 8'hE7, 8'h00, 8'h00, "R3 unmasked line 4 served", -1);

        // R6 / R11 call mode
        cfg_write(2'd1, 8'h01);
        cfg_write(2'd2, 8'h00);
        cfg_write(2'd3, 8'h12);
        pulse_line(1);
        serve(3, 8'hCD, 8'h04, 8'h12, "R6 call line 1", -1);
        cfg_write(2'd2, 8'hFE);
        pulse_line(1);
        serve(3, 8'hCD, 8'h02, 8'h13, "R6 call target carry", -1);

        // R9 later higher-priority request does not disturb the call in progress
        cfg_write(2'd2, 8'h00);
        cfg_write(2'd3, 8'h40);
        pulse_line(6);
        serve(3, 8'hCD, 8'h18, 8'h40, "R9 winner held line 6", 0);
        serve(3, 8'hCD, 8'h00, 8'h40, "R9 late line 0 served next", -1);
        idle(5);
        @(negedge clk);
        check(cpu_intr == 1'b0, "R10 pending cleared after call", int'(cpu_intr), 0);

        // R12 abandoned acknowledge
        cfg_write(2'd1, 8'h00);
        pulse_line(2);
        wait_intr("R12 first request");
        @(posedge clk); #1 cpu_inta = 1;
        idle(2);
        cpu_inta = 0;
        wait_intr("R12 request raised again");
        serve(1, 8'hD7, 8'h00, 8'h00, "R12 line 2 served after abort", -1);

        idle(4);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule